// File: doc/BRIEF.md
# Indexed Byte Read-Modify-Write Sequencer

This block runs the memory-operand byte logic operations of a small processor core, plus its atomic test-and-set. The core hands over a 16-bit instruction word, the two base registers whose sum forms the byte address for the logic operations, and the general register that holds the address for test-and-set. The block then drives a plain byte memory port through a fixed sequence: read, capture, optional hold, then write back or flag update.

The masked logic operations (AND, OR, XOR) read a byte, combine it with the 8-bit immediate taken from the instruction word, and store the result at the same address. The test operation reads the byte and only updates the T flag. Test-and-set reads the byte, reports in T whether it was zero, and writes it back with its top bit set. For test-and-set the block holds a lock output from the read through the write, so that an external arbiter can keep other agents off the bus for that span.

Top module: `gbr_byte_rmw`

## Requirements
- R1: The instruction word is decoded as follows: upper byte 0xCD is AND, 0xCC is TST, 0xCE is XOR, 0xCF is OR, with the immediate in the lower byte; a word with upper nibble 0x4 and lower byte 0x1B is TAS, whatever bits 11:8 hold. A start with any other word is not accepted: busy stays low and no memory strobe appears.
- R2: The byte address is the sum of the two base registers, modulo 2^ADDR_W, for AND, OR, XOR and TST, and the general register for TAS. All operands are captured at acceptance, and the address output stays constant until the operation ends.
- R3: The read strobe is high for exactly one cycle, the first cycle after acceptance. Read data is expected one cycle after the strobe. Read and write strobes are never high together.
- R4: AND, OR and XOR take 3 cycles. In the third cycle the write strobe is high at the same address, with the read byte combined with the immediate. They leave T unchanged.
- R5: TST takes 3 cycles and performs no write. T becomes 1 when the read byte ANDed with the immediate is zero, and 0 otherwise.
- R6: TAS takes 4 cycles. T becomes 1 when the read byte is zero, and 0 otherwise. In the fourth cycle the read byte is written back with bit 7 set.
- R7: For TAS, lock is high in every cycle from the read cycle through the write cycle, and it falls only after the write. It is never high for the other operations.
- R8: Busy is high from the cycle after acceptance through the final cycle. A start that arrives while busy is ignored and does not alter the running operation.
- R9: Done is a one-cycle pulse in the final cycle. T changes only at the clock edge that ends a done cycle, and busy is low in the following cycle.
- R10: After reset the block is idle, with busy, done, lock, both strobes and T all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin the instruction on insn_i |
| insn_i | input | INSN_W | Instruction word |
| r0_i | input | REG_W | First base register (index) |
| gbr_i | input | REG_W | Second base register |
| rn_i | input | REG_W | General register holding the test-and-set address |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | BYTE_W | Write data |
| mem_rdata_i | input | BYTE_W | Read data, valid one cycle after the read strobe |
| lock_o | output | 1 | Bus lock, held during a test-and-set |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | Final cycle of the operation |
| t_o | output | 1 | T flag |

## Verification
The checker watches, on every cycle, the ordering of the port protocol: lock held only while busy, rising with the read and falling only after a write; strobes never overlapping; writes only in a done cycle; bit 7 set on a locked write; a stable address; and T moving only at the end of a done cycle. The bench scenarios alone can show the values involved: the decoded operation, the computed write byte, the T result against a model of memory, the per-operation cycle counts, operands captured at acceptance, and the rejection of undecodable or overlapping starts.

// File: rtl/gbr_rmw_pkg.sv
package gbr_rmw_pkg;
   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_AND  = 3'd1,
      OP_OR   = 3'd2,
      OP_XOR  = 3'd3,
      OP_TST  = 3'd4,
      OP_TAS  = 3'd5
   } rmw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_READ = 3'd1,
      ST_CAPT = 3'd2,
      ST_HOLD = 3'd3,
      ST_LAST = 3'd4
   } rmw_st_e;

   localparam int IMM_BITS = 8;
endpackage

// File: rtl/gbr_rmw_decode.sv
module gbr_rmw_decode
   import gbr_rmw_pkg::*;
#(
   parameter int INSN_W = 16
) (
   input  logic [INSN_W-1:0]   insn_i,
   output rmw_op_e             op_o,
   output logic [IMM_BITS-1:0] imm_o
);
   localparam int TOP_LO = INSN_W - 8;

   generate
      if (INSN_W != 16) begin : g_bad_width
         $error("gbr_rmw_decode: INSN_W must be 16");
      end
   endgenerate

   logic [7:0] top_byte;
   assign top_byte = insn_i[INSN_W-1:TOP_LO];
   assign imm_o    = insn_i[IMM_BITS-1:0];

   always_comb begin
      op_o = OP_NONE;
      case (top_byte)
         8'hCD:   op_o = OP_AND;
         8'hCC:   op_o = OP_TST;
         8'hCE:   op_o = OP_XOR;
         8'hCF:   op_o = OP_OR;
         default: op_o = OP_NONE;
      endcase
      if (top_byte[7:4] == 4'h4 && insn_i[7:0] == 8'h1B) begin
         op_o = OP_TAS;
      end
   end
endmodule

// File: rtl/gbr_rmw_alu.sv
module gbr_rmw_alu
   import gbr_rmw_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int TAS_BIT = BYTE_W - 1
) (
   input  rmw_op_e           op_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic [BYTE_W-1:0] imm_i,
   output logic [BYTE_W-1:0] wdata_o,
   output logic              tflag_o
);
   localparam logic [BYTE_W-1:0] SET_MASK = {{(BYTE_W-1){1'b0}}, 1'b1} << TAS_BIT;

   generate
      if (TAS_BIT >= BYTE_W || TAS_BIT < 0) begin : g_bad_bit
         $error("gbr_rmw_alu: TAS_BIT outside the byte");
      end
   endgenerate

   always_comb begin
      case (op_i)
         OP_AND:  wdata_o = data_i & imm_i;
         OP_OR:   wdata_o = data_i | imm_i;
         OP_XOR:  wdata_o = data_i ^ imm_i;
         OP_TAS:  wdata_o = data_i | SET_MASK;
         default: wdata_o = data_i;
      endcase
   end

   always_comb begin
      case (op_i)
         OP_TST:  tflag_o = ((data_i & imm_i) == '0);
         OP_TAS:  tflag_o = (data_i == '0);
         default: tflag_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/gbr_rmw_ctrl.sv
module gbr_rmw_ctrl
   import gbr_rmw_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    go_i,
   input  rmw_op_e op_i,
   output rmw_op_e op_q_o,
   output logic    busy_o,
   output logic    rd_o,
   output logic    capt_o,
   output logic    last_o,
   output logic    lock_o
);
   rmw_st_e st_q, st_d;
   rmw_op_e op_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (go_i) st_d = ST_READ;
         ST_READ: st_d = ST_CAPT;
         ST_CAPT: st_d = (op_q == OP_TAS) ? ST_HOLD : ST_LAST;
         ST_HOLD: st_d = ST_LAST;
         ST_LAST: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         op_q <= OP_NONE;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && go_i) begin
            op_q <= op_i;
         end
      end
   end

   assign op_q_o = op_q;
   assign busy_o = (st_q != ST_IDLE);
   assign rd_o   = (st_q == ST_READ);
   assign capt_o = (st_q == ST_CAPT);
   assign last_o = (st_q == ST_LAST);
   assign lock_o = busy_o && (op_q == OP_TAS);
endmodule

// File: rtl/gbr_byte_rmw.sv
module gbr_byte_rmw
   import gbr_rmw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 32,
   parameter int BYTE_W = 8,
   parameter int INSN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [REG_W-1:0]  r0_i,
   input  logic [REG_W-1:0]  gbr_i,
   input  logic [REG_W-1:0]  rn_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [BYTE_W-1:0] mem_wdata_o,
   input  logic [BYTE_W-1:0] mem_rdata_i,
   output logic              lock_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              t_o
);
   localparam int MSB_BIT = BYTE_W - 1;

   generate
      if (ADDR_W > REG_W || ADDR_W < 1) begin : g_bad_addr
         $error("gbr_byte_rmw: ADDR_W must be 1..REG_W");
      end
      if (BYTE_W != IMM_BITS) begin : g_bad_byte
         $error("gbr_byte_rmw: BYTE_W must match the immediate width");
      end
   endgenerate

   rmw_op_e             dec_op;
   logic [IMM_BITS-1:0] dec_imm;
   rmw_op_e             op_q;
   logic                go, capt, last;
   logic [REG_W-1:0]    sum_full;
   logic [ADDR_W-1:0]   sum_addr, rn_addr;
   logic [ADDR_W-1:0]   ea_q;
   logic [BYTE_W-1:0]   imm_q, data_q, alu_wdata;
   logic                alu_t, t_q;

   gbr_rmw_decode #(.INSN_W(INSN_W)) u_dec (
      .insn_i (insn_i),
      .op_o   (dec_op),
      .imm_o  (dec_imm)
   );

   assign go = start_i && !busy_o && (dec_op != OP_NONE);

   gbr_rmw_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (go),
      .op_i   (dec_op),
      .op_q_o (op_q),
      .busy_o (busy_o),
      .rd_o   (mem_rd_o),
      .capt_o (capt),
      .last_o (last),
      .lock_o (lock_o)
   );

   assign sum_full = r0_i + gbr_i;

   generate
      if (ADDR_W == REG_W) begin : g_addr_full
         assign sum_addr = sum_full;
         assign rn_addr  = rn_i;
      end else begin : g_addr_slice
         assign sum_addr = sum_full[ADDR_W-1:0];
         assign rn_addr  = rn_i[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_q   <= '0;
         imm_q  <= '0;
         data_q <= '0;
         t_q    <= 1'b0;
      end else begin
         if (go) begin
            ea_q  <= (dec_op == OP_TAS) ? rn_addr : sum_addr;
            imm_q <= dec_imm;
         end
         if (capt) begin
            data_q <= mem_rdata_i;
         end
         if (last && (op_q == OP_TST || op_q == OP_TAS)) begin
            t_q <= alu_t;
         end
      end
   end

   gbr_rmw_alu #(.BYTE_W(BYTE_W), .TAS_BIT(MSB_BIT)) u_alu (
      .op_i    (op_q),
      .data_i  (data_q),
      .imm_i   (imm_q),
      .wdata_o (alu_wdata),
      .tflag_o (alu_t)
   );

   assign mem_addr_o  = ea_q;
   assign mem_wr_o    = last && (op_q != OP_TST);
   assign mem_wdata_o = mem_wr_o ? alu_wdata : '0;
   assign done_o      = last;
   assign t_o         = t_q;
endmodule

// File: rtl/gbr_byte_rmw_chk.sv
module gbr_byte_rmw_chk #(
   parameter int ADDR_W = 32,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic [BYTE_W-1:0] mem_wdata_o,
   input logic              lock_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              t_o
);
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

   assert_no_rd_wr_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));

   assert_read_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> mem_rd_o);

   assert_write_in_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> done_o);

   assert_locked_write_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && lock_o) |-> mem_wdata_o[BYTE_W-1]);

   assert_lock_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> busy_o);

   assert_lock_rises_with_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> mem_rd_o);

   assert_lock_falls_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_o) |-> $past(mem_wr_o));

   assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   assert_done_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_t_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |=> $stable(t_o));
endmodule

bind gbr_byte_rmw gbr_byte_rmw_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .mem_addr_o  (mem_addr_o),
   .mem_rd_o    (mem_rd_o),
   .mem_wr_o    (mem_wr_o),
   .mem_wdata_o (mem_wdata_o),
   .lock_o      (lock_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .t_o         (t_o)
);

// File: tb/gbr_byte_rmw_bench.sv
module gbr_byte_rmw_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] insn_i = '0;
   logic [31:0] r0_i = '0, gbr_i = '0, rn_i = '0;
   logic [31:0] mem_addr_o;
   logic        mem_rd_o, mem_wr_o, lock_o, busy_o, done_o, t_o;
   logic [7:0]  mem_wdata_o;
   logic [7:0]  mem_rdata_i = '0;

   logic [7:0]  mem [16];
   logic [7:0]  exp_mem [16];
   bit          exp_t = 1'b0;
   int          n_vec = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   gbr_byte_rmw u_gbr_byte_rmw (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
      .r0_i(r0_i), .gbr_i(gbr_i), .rn_i(rn_i),
      .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .lock_o(lock_o), .busy_o(busy_o), .done_o(done_o), .t_o(t_o)
   );

   always @(posedge clk) begin
      if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[3:0]];
      if (mem_wr_o) mem[mem_addr_o[3:0]] <= mem_wdata_o;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // op codes: 0 AND, 1 OR, 2 XOR, 3 TST, 4 TAS
   function automatic logic [15:0] mk_insn(input int op, input logic [7:0] imm,
                                           input logic [3:0] reg_n);
      case (op)
         0: return {8'hCD, imm};
         1: return {8'hCF, imm};
         2: return {8'hCE, imm};
         3: return {8'hCC, imm};
         default: return {4'h4, reg_n, 8'h1B};
      endcase
   endfunction

   function automatic logic [7:0] exp_byte(input int op, input logic [7:0] b,
                                           input logic [7:0] imm);
      case (op)
         0: return b & imm;
         1: return b | imm;
         2: return b ^ imm;
         3: return b;
         default: return b | 8'h80;
      endcase
   endfunction

   task automatic set_byte(input int idx, input logic [7:0] v);
      mem[idx] = v;
      exp_mem[idx] = v;
   endtask

   task automatic run_op(input int op, input logic [7:0] imm, input logic [31:0] r0,
                         input logic [31:0] gbr, input logic [31:0] rn, input bit poke);
      int          n;
      logic [31:0] ea;
      logic [7:0]  old, nb;
      bit          nt;
      n  = (op == 4) ? 4 : 3;
      ea = (op == 4) ? rn : r0 + gbr;
      old = exp_mem[ea[3:0]];
      nb  = exp_byte(op, old, imm);
      nt  = exp_t;
      if (op == 3) nt = ((old & imm) == 8'h00);
      if (op == 4) nt = (old == 8'h00);
      @(negedge clk);
      start_i = 1'b1;
      insn_i  = mk_insn(op, imm, rn[3:0]);
      r0_i = r0; gbr_i = gbr; rn_i = rn;
      for (int c = 1; c <= n + 1; c++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (c == 1) begin
            chk(busy_o == 1'b1, "R8", "busy after accept", busy_o, 1);
            chk(mem_rd_o == 1'b1, "R3", "read strobe first cycle", mem_rd_o, 1);
            chk(mem_addr_o == ea, "R2", "address", mem_addr_o, ea);
            r0_i = $urandom; gbr_i = $urandom; rn_i = $urandom;
         end
         if (c == 2 && poke) begin
            start_i = 1'b1;
            insn_i  = mk_insn(int'($urandom % 5), 8'($urandom), 4'h0);
         end
         if (c > 1 && c <= n) begin
            chk(mem_rd_o == 1'b0, "R3", "read strobe single", mem_rd_o, 0);
            chk(mem_addr_o == ea, "R2", "address held", mem_addr_o, ea);
            chk(busy_o == 1'b1, "R8", "busy during op", busy_o, 1);
         end
         if (c <= n)
            chk(lock_o == (op == 4), "R7", "lock level", lock_o, (op == 4));
         if (c > 1 && c < n) begin
            chk(mem_wr_o == 1'b0, "R4", "no early write", mem_wr_o, 0);
            chk(done_o == 1'b0, "R9", "no early done", done_o, 0);
         end
         if (c == n) begin
            chk(done_o == 1'b1, "R9", "done in final cycle", done_o, 1);
            if (op == 3) begin
               chk(mem_wr_o == 1'b0, "R5", "TST does not write", mem_wr_o, 0);
            end else begin
               chk(mem_wr_o == 1'b1, (op == 4) ? "R6" : "R4", "write strobe", mem_wr_o, 1);
               chk(mem_wdata_o == nb, (op == 4) ? "R6" : "R4", "write data", mem_wdata_o, nb);
            end
            chk(t_o == exp_t, "R9", "T before final edge", t_o, exp_t);
         end
         if (c == n + 1) begin
            chk(busy_o == 1'b0 && done_o == 1'b0 && lock_o == 1'b0, "R9",
                "idle after done", {busy_o, done_o, lock_o}, 0);
            chk(t_o == nt, (op == 3) ? "R5" : (op == 4) ? "R6" : "R4", "T result", t_o, nt);
         end
      end
      start_i = 1'b0;
      exp_mem[ea[3:0]] = nb;
      exp_t = nt;
      chk(mem[ea[3:0]] == nb, (op == 4) ? "R6" : "R4", "memory byte", mem[ea[3:0]], nb);
   endtask

   task automatic try_bad(input logic [15:0] w);
      @(negedge clk);
      start_i = 1'b1;
      insn_i  = w;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b0 && mem_rd_o == 1'b0, "R1", "undecodable word ignored",
          {busy_o, mem_rd_o}, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) set_byte(i, 8'(i * 37 + 5));
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && lock_o == 0 && mem_rd_o == 0 &&
          mem_wr_o == 0 && t_o == 0, "R10", "reset state",
          {busy_o, done_o, lock_o, mem_rd_o, mem_wr_o, t_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 0 && t_o == 0, "R10", "idle after release", {busy_o, t_o}, 0);

      // R1: words that must not decode
      try_bad(16'h1234);
      try_bad(16'h401A);
      try_bad(16'hCB12);
      try_bad(16'h501B);

      // R6: TAS on a zero byte and on a byte with bit 7 already set
      set_byte(3, 8'h00);
      run_op(4, 8'h00, 32'h0, 32'h0, 32'h0000_0003, 1'b0);
      run_op(4, 8'h00, 32'h0, 32'h0, 32'h0000_0003, 1'b0);
      // R5: TST with zero immediate always yields T=1, then a nonzero overlap
      run_op(3, 8'h00, 32'h10, 32'h5, 32'h0, 1'b0);
      set_byte(7, 8'h0F);
      run_op(3, 8'h08, 32'h3, 32'h4, 32'h0, 1'b0);
      // R4: logic ops keep T, and the sum wraps modulo 2^32 (R2)
      run_op(0, 8'hFF, 32'hFFFF_FFFF, 32'h2, 32'h0, 1'b0);
      run_op(2, 8'h00, 32'h8000_0000, 32'h8000_0009, 32'h0, 1'b0);
      run_op(1, 8'hA5, 32'h1, 32'h1, 32'h0, 1'b0);
      // R8: starts during busy are ignored
      run_op(0, 8'h3C, 32'h6, 32'h0, 32'h0, 1'b1);
      run_op(4, 8'h00, 32'h0, 32'h0, 32'h0000_000C, 1'b1);

      for (int k = 0; k < 300; k++) begin
         run_op(int'($urandom % 5), 8'($urandom), $urandom, $urandom, $urandom,
                ($urandom % 4) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule